// File: doc/BRIEF.md
# RV32 Next-PC and Branch Unit

This block decides where an RV32 hart goes next after a control-transfer instruction, and what value such an instruction leaves in its destination register. It holds the program counter itself. Each cycle it takes an operation code that the decoder has already produced, the two source register values and the immediates. The decoder supplies the immediates already sign-extended, and the block never slices an instruction word. The comparison, target, link value, write enable, taken flag and misalignment flag are combinational and are visible in the same cycle as the operation. The program counter register loads the new target at the next clock edge.

The operation interface has no back-pressure. The unit can take one operation in every cycle, so it has a valid strobe and no ready. A cycle with the strobe low is a bubble: the program counter holds and every status output reads zero. A target whose two low bits are not both zero is reported instead of being followed. The program counter then stays where it was, so that the surrounding pipeline can raise its own exception.

Top module: `npc_unit`

## Requirements
- R1: After reset `pc_q` equals the parameter RESET_PC (default 0x0000_1000), and `rd_we`, `taken` and `misaligned` read 0 while `op_valid` is low.
- R2: Operation codes: 0 none, 1 BEQ, 2 BNE, 3 BLT, 4 BGE, 5 BLTU, 6 BGEU, 7 JAL, 8 JALR, 9 LUI. BEQ is taken when the two operands are equal, and BNE when they differ.
- R3: BLT is taken when operand A is below operand B, both read as signed 32-bit values. BGE is taken when A is greater than or equal to B under the same reading.
- R4: BLTU and BGEU use the same rules as BLT and BGE, with both operands read as unsigned values.
- R5: For a taken branch `next_pc` is `pc_q + imm_b` and `taken` is 1. For a branch that is not taken `next_pc` is `pc_q + 4` and `taken` is 0. Branches put 0 on `link_data`.
- R6: JAL gives `next_pc = pc_q + imm_j`, `link_data = pc_q + 4` and `taken = 1`.
- R7: JALR gives `next_pc = (rs1_val + imm_i)` with bit 0 cleared, `link_data = pc_q + 4` and `taken = 1`.
- R8: LUI gives `link_data = imm_u << 12`, `next_pc = pc_q + 4` and `taken = 0`.
- R9: `rd_we` is high only for a valid JAL, JALR or LUI with `rd_idx` other than 0 and no misalignment. Branches and the none operation never write.
- R10: `misaligned` is high for a valid operation whose `next_pc` has bit 1 or bit 0 set. In that cycle `pc_q` is not updated.
- R11: `pc_q` loads `next_pc` at the clock edge that ends a cycle with `op_valid` high and `misaligned` low, and holds in every other cycle.
- R12: Codes 10 to 15 behave like the none operation: `next_pc = pc_q + 4`, with no write, no taken flag and `link_data = 0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation code (see R2) |
| rd_idx | input | 5 | Destination register index |
| rs1_val | input | 32 | Operand A |
| rs2_val | input | 32 | Operand B |
| imm_b | input | 32 | Sign-extended branch offset |
| imm_j | input | 32 | Sign-extended jump offset |
| imm_i | input | 32 | Sign-extended register-jump offset |
| imm_u | input | 20 | Upper immediate, before the shift |
| pc_q | output | 32 | Current program counter |
| next_pc | output | 32 | Computed target of the present operation |
| link_data | output | 32 | Value for the destination register |
| rd_we | output | 1 | Destination register write enable |
| taken | output | 1 | Control transfer taken |
| misaligned | output | 1 | Target not on a 4-byte boundary |

## Verification
`next_pc`, `link_data`, `rd_we`, `taken` and `misaligned` depend only on `pc_q` and the inputs of the same cycle. The bench drives the inputs just after a falling edge and samples these outputs one nanosecond later, before the next rising edge. `pc_q` changes one rising edge after the operation, so the bench checks it at the following falling edge against a program counter it tracks itself. The bench sweeps every branch over an 8-by-8 grid of corner operands, covers jumps with aligned and misaligned offsets and with destination 0, and adds bubble cycles and the unused codes.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int OP_W = 4;
  localparam logic [OP_W-1:0] OP_NONE = 4'd0;
  localparam logic [OP_W-1:0] OP_BEQ  = 4'd1;
  localparam logic [OP_W-1:0] OP_BNE  = 4'd2;
  localparam logic [OP_W-1:0] OP_BLT  = 4'd3;
  localparam logic [OP_W-1:0] OP_BGE  = 4'd4;
  localparam logic [OP_W-1:0] OP_BLTU = 4'd5;
  localparam logic [OP_W-1:0] OP_BGEU = 4'd6;
  localparam logic [OP_W-1:0] OP_JAL  = 4'd7;
  localparam logic [OP_W-1:0] OP_JALR = 4'd8;
  localparam logic [OP_W-1:0] OP_LUI  = 4'd9;
endpackage

// File: rtl/npc_branch_cmp.sv
module npc_branch_cmp
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [OP_W-1:0] op,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  output logic            is_branch,
  output logic            cond_met
);
  logic eq, lt_s, lt_u;

  always_comb begin
    eq   = (opnd_a == opnd_b);
    lt_s = ($signed(opnd_a) < $signed(opnd_b));
    lt_u = (opnd_a < opnd_b);
  end

  always_comb begin
    is_branch = 1'b1;
    cond_met  = 1'b0;
    case (op)
      OP_BEQ:  cond_met = eq;
      OP_BNE:  cond_met = !eq;
      OP_BLT:  cond_met = lt_s;
      OP_BGE:  cond_met = !lt_s;
      OP_BLTU: cond_met = lt_u;
      OP_BGEU: cond_met = !lt_u;
      default: is_branch = 1'b0;
    endcase
  end

  // R3
  always_comb begin
    if (eq) eq_order_chk: assert (!lt_s && !lt_u);
  end
endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen
  import npc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int UPPER = 20
) (
  input  logic [OP_W-1:0]  op,
  input  logic [XLEN-1:0]  pc,
  input  logic             cond_met,
  input  logic [XLEN-1:0]  rs1_val,
  input  logic [XLEN-1:0]  imm_b,
  input  logic [XLEN-1:0]  imm_j,
  input  logic [XLEN-1:0]  imm_i,
  input  logic [UPPER-1:0] imm_u,
  output logic [XLEN-1:0]  target,
  output logic [XLEN-1:0]  link,
  output logic             writes_rd,
  output logic             xfer
);
  localparam int LOW_BITS = XLEN - UPPER;
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  logic [XLEN-1:0] seq_pc, reg_sum;

  always_comb begin
    seq_pc  = pc + INSN_BYTES;
    reg_sum = rs1_val + imm_i;
  end

  always_comb begin
    target    = seq_pc;
    link      = '0;
    writes_rd = 1'b0;
    xfer      = 1'b0;
    case (op)
      OP_BEQ, OP_BNE, OP_BLT, OP_BGE, OP_BLTU, OP_BGEU: begin
        xfer   = cond_met;
        target = cond_met ? pc + imm_b : seq_pc;
      end
      OP_JAL: begin
        target    = pc + imm_j;
        link      = seq_pc;
        writes_rd = 1'b1;
        xfer      = 1'b1;
      end
      OP_JALR: begin
        target    = {reg_sum[XLEN-1:1], 1'b0};
        link      = seq_pc;
        writes_rd = 1'b1;
        xfer      = 1'b1;
      end
      OP_LUI: begin
        link      = {imm_u, {LOW_BITS{1'b0}}};
        writes_rd = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = 32'h0000_1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [3:0]       op_code,
  input  logic [4:0]       rd_idx,
  input  logic [XLEN-1:0]  rs1_val,
  input  logic [XLEN-1:0]  rs2_val,
  input  logic [XLEN-1:0]  imm_b,
  input  logic [XLEN-1:0]  imm_j,
  input  logic [XLEN-1:0]  imm_i,
  input  logic [XLEN-13:0] imm_u,
  output logic [XLEN-1:0]  pc_q,
  output logic [XLEN-1:0]  next_pc,
  output logic [XLEN-1:0]  link_data,
  output logic             rd_we,
  output logic             taken,
  output logic             misaligned
);
  localparam int UPPER = XLEN - 12;

  logic is_branch, cond_met, writes_rd, xfer;

  npc_branch_cmp #(.XLEN(XLEN)) u_cmp (
    .op(op_code), .opnd_a(rs1_val), .opnd_b(rs2_val),
    .is_branch(is_branch), .cond_met(cond_met)
  );

  npc_target_gen #(.XLEN(XLEN), .UPPER(UPPER)) u_tgt (
    .op(op_code), .pc(pc_q), .cond_met(cond_met), .rs1_val(rs1_val),
    .imm_b(imm_b), .imm_j(imm_j), .imm_i(imm_i), .imm_u(imm_u),
    .target(next_pc), .link(link_data), .writes_rd(writes_rd), .xfer(xfer)
  );

  always_comb begin
    misaligned = op_valid && (next_pc[1:0] != 2'b00);
    rd_we      = op_valid && writes_rd && (rd_idx != 5'd0) && !misaligned;
    taken      = op_valid && xfer;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pc_q <= RESET_PC;
    else if (op_valid && !misaligned) pc_q <= next_pc;
  end

  // R11
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(pc_q));
  // R10
  misalign_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misaligned |=> $stable(pc_q));
  // R11
  pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !misaligned) |=> (pc_q == $past(next_pc)));
  // R10
  pc_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q[1:0] == 2'b00);
  // R9
  branch_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_branch |-> !rd_we);
  // R9
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == 5'd0) |-> !rd_we);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !(rd_we || taken || misaligned));
endmodule

// File: tb/npc_unit_bench.sv
module npc_unit_bench;
  localparam logic [31:0] RST_PC = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [4:0]  rd_idx = '0;
  logic [31:0] rs1_val = '0, rs2_val = '0, imm_b = '0, imm_j = '0, imm_i = '0;
  logic [19:0] imm_u = '0;
  logic [31:0] pc_q, next_pc, link_data;
  logic        rd_we, taken, misaligned;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_pc;
  logic [31:0] vals [8];

  always #2 clk = ~clk;

  npc_unit #(.XLEN(32), .RESET_PC(RST_PC)) u_npc_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .rd_idx(rd_idx), .rs1_val(rs1_val), .rs2_val(rs2_val), .imm_b(imm_b),
    .imm_j(imm_j), .imm_i(imm_i), .imm_u(imm_u), .pc_q(pc_q),
    .next_pc(next_pc), .link_data(link_data), .rd_we(rd_we),
    .taken(taken), .misaligned(misaligned)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // Apply one operation, check combinational results, then the PC update.
  task automatic step(input logic v, input logic [3:0] op, input logic [4:0] rd,
                      input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] ib, input logic [31:0] ij,
                      input logic [31:0] ii, input logic [19:0] iu,
                      input string req);
    logic [31:0] e_next, e_link;
    logic cnd, e_tk, e_wr, e_mis, is_br, is_jmp;
    op_valid = v; op_code = op; rd_idx = rd; rs1_val = a; rs2_val = b;
    imm_b = ib; imm_j = ij; imm_i = ii; imm_u = iu;
    cnd = 1'b0;
    case (op)
      4'd1: cnd = (a == b);
      4'd2: cnd = (a != b);
      4'd3: cnd = ($signed(a) < $signed(b));
      4'd4: cnd = ($signed(a) >= $signed(b));
      4'd5: cnd = (a < b);
      4'd6: cnd = (a >= b);
      default: cnd = 1'b0;
    endcase
    is_br  = (op >= 4'd1) && (op <= 4'd6);
    is_jmp = (op == 4'd7) || (op == 4'd8);
    e_next = exp_pc + 32'd4;
    e_link = 32'd0;
    if (is_br && cnd) e_next = exp_pc + ib;
    if (op == 4'd7) e_next = exp_pc + ij;
    if (op == 4'd8) e_next = (a + ii) & 32'hFFFF_FFFE;
    if (is_jmp) e_link = exp_pc + 32'd4;
    if (op == 4'd9) e_link = iu * 32'd4096;
    e_mis = v && (e_next % 4 != 0);
    e_tk  = v && ((is_br && cnd) || is_jmp);
    e_wr  = v && (is_jmp || op == 4'd9) && rd != 0 && !e_mis;
    #1;
    check(req, "next_pc", next_pc, e_next);
    check(req, "taken", {31'd0, taken}, {31'd0, e_tk});
    check("R9", "rd_we", {31'd0, rd_we}, {31'd0, e_wr});
    check("R10", "misaligned", {31'd0, misaligned}, {31'd0, e_mis});
    check(req, "link_data", link_data, e_link);
    if (v && !e_mis) exp_pc = e_next;
    @(negedge clk);
    check("R11", "pc_q", pc_q, exp_pc);
  endtask

  initial begin
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h0000_0005;
    vals[6] = 32'hFFFF_FFFB; vals[7] = 32'h0000_0002;
    exp_pc = RST_PC;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "pc_q reset", pc_q, RST_PC);
    check("R1", "idle flags", {29'd0, rd_we, taken, misaligned}, 32'd0);

    // R2 R3 R4 R5: every branch over an 8x8 operand grid
    for (int op = 1; op <= 6; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          step(1'b1, 4'(op), 5'(i + j + 1), vals[i], vals[j],
               ((i + j) % 2 == 0) ? 32'd8 : 32'hFFFF_FFF4, 32'd0, 32'd0, 20'd0,
               (op <= 2) ? "R2" : (op <= 4) ? "R3" : "R4");
    // R5 R10 misaligned branch offset, taken and not taken
    step(1'b1, 4'd1, 5'd3, 32'd7, 32'd7, 32'd6, 32'd0, 32'd0, 20'd0, "R10");
    step(1'b1, 4'd2, 5'd3, 32'd7, 32'd7, 32'd6, 32'd0, 32'd0, 20'd0, "R5");

    // R6 JAL with various offsets and destinations
    for (int k = 0; k < 4; k++)
      for (int r = 0; r < 3; r++)
        step(1'b1, 4'd7, (r == 0) ? 5'd0 : (r == 1) ? 5'd1 : 5'd31, 32'd0, 32'd0,
             32'd0, (k == 0) ? 32'd4 : (k == 1) ? 32'hFFFF_FFF8 :
                    (k == 2) ? 32'h0000_0800 : 32'd6, 32'd0, 20'd0, "R6");

    // R7 JALR: bit 0 cleared, bit 1 flagged
    for (int i = 0; i < 8; i++)
      for (int k = 0; k < 5; k++)
        step(1'b1, 4'd8, 5'd9, 32'h0000_2000 + vals[i], 32'd0, 32'd0, 32'd0,
             (k == 0) ? 32'd0 : (k == 1) ? 32'd1 : (k == 2) ? 32'd3 :
             (k == 3) ? 32'hFFFF_FFFF : 32'd4, 20'd0, "R7");

    // R8 LUI
    step(1'b1, 4'd9, 5'd4, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 20'hABCDE, "R8");
    step(1'b1, 4'd9, 5'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 20'hFFFFF, "R8");
    step(1'b1, 4'd9, 5'd17, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 20'h00001, "R8");

    // R12 none and unused codes
    for (int c = 0; c < 16; c++)
      if (c == 0 || c >= 10)
        step(1'b1, 4'(c), 5'd5, 32'd3, 32'd3, 32'd16, 32'd16, 32'd16, 20'h1, "R12");

    // R11 bubble cycles: taken branch and jump presented with strobe low
    step(1'b0, 4'd1, 5'd5, 32'd9, 32'd9, 32'd64, 32'd0, 32'd0, 20'd0, "R11");
    step(1'b0, 4'd7, 5'd5, 32'd0, 32'd0, 32'd0, 32'd128, 32'd0, 20'd0, "R11");
    step(1'b0, 4'd8, 5'd5, 32'd2, 32'd0, 32'd0, 32'd0, 32'd0, 20'd0, "R11");

    // R1 reset again returns the vector
    rst_n = 1'b0;
    op_valid = 1'b0;
    #1;
    exp_pc = RST_PC;
    check("R1", "pc_q re-reset", pc_q, RST_PC);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule